// File: doc/BRIEF.md
# Timed PCM Sample Player

This block streams raw 8-bit samples out of CPU memory into a 7-bit DAC at a fixed pace. Software sets a start address and a sample count through two write-only registers, then starts playback through a control register. While running, a countdown timer is drained by the CPU cycle counts reported on a tick input. Each time the timer runs out, one byte is fetched over a simple request/acknowledge memory port. The byte is halved and presented on the DAC output. Once the programmed count is used up, the next expiry raises a completion flag and an interrupt, and playback stops.

The completion flag is merged into bit 7 of the sound unit's status byte. Any write to the control register clears the flag and the interrupt. The memory system and the remaining sound channels sit outside this block.

Top module: `pcm_sample_player`

## Requirements
- R1: After reset, `irq` is 0, `mem_req` is 0, `dac_val` is 0 and playback is stopped.
- R2: A write to 0x4012 sets the fetch address to the data byte shifted left by 6 bits. The next fetch uses that address.
- R3: A write to 0x4013 sets the sample count to data*16+1. Playback then fetches exactly that many bytes before completing.
- R4: A write to 0x4015 starts playback when data bit 4 is 1 and stops it when bit 4 is 0. A start reloads the timer with 246 cycles. Every write to 0x4015 clears the completion flag and `irq`.
- R5: On each `cyc_tick` while playing, the timer drops by `cyc_step`. When the result is zero or below, the period is added back to that result (the overshoot carries over) and one sample slot is consumed.
- R6: A consumed slot raises `mem_req` with `mem_addr`. Both are held until `mem_ack`. `dac_val` becomes `mem_rdata[7:1]` one cycle after the acknowledged cycle.
- R7: After each acknowledged fetch the address increments by one and wraps within 15 bits, so 0x7FFF is followed by 0x0000.
- R8: When a slot is consumed with the count already at zero, no fetch is made. The completion flag and `irq` are set, and playback stops.
- R9: `status_out` equals `base_status` with bit 7 replaced by the completion flag.
- R10: Ticks have no effect while playback is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| base_status | input | 8 | Status byte from the rest of the sound unit |
| status_out | output | 8 | Merged status byte for reads of 0x4015 |
| cyc_tick | input | 1 | Elapsed-cycle report valid |
| cyc_step | input | 8 | CPU cycles elapsed for this report |
| mem_req | output | 1 | Sample fetch request |
| mem_addr | output | 15 | Sample fetch address |
| mem_ack | input | 1 | Fetch acknowledge, data valid |
| mem_rdata | input | 8 | Fetched byte |
| dac_val | output | 7 | DAC level |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check four things on every cycle:
- a pending request keeps its address until it is acknowledged;
- every acknowledge advances the address by one, modulo 2^15, and the DAC follows the acknowledged byte one cycle later;
- the status bit mirrors the interrupt, and a control write leaves the interrupt low;
- the interrupt only rises with playback stopped.

Only the bench scenarios can show the timing and counting behaviour:
- the exact tick counts between fetches, including the carried overshoot;
- the number of fetches a given count value yields;
- the 15-bit wrap after a long run;
- that a stopped player ignores ticks.

// File: rtl/pcm_sample_player.sv
module pcm_sample_player #(
  parameter int AW       = 15,
  parameter int LW       = 14,
  parameter int TW       = 12,
  parameter int STEP_W   = 8,
  parameter int PERIOD   = 246,
  parameter logic [15:0] A_BASE = 16'h4012,
  parameter logic [15:0] A_LEN  = 16'h4013,
  parameter logic [15:0] A_CTL  = 16'h4015
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        base_status,
  output logic [7:0]        status_out,
  input  logic              cyc_tick,
  input  logic [STEP_W-1:0] cyc_step,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic [6:0]        dac_val,
  output logic              irq
);
  localparam logic signed [TW-1:0] PER_S = TW'(PERIOD);

  logic                 en, done, dac_pend;
  logic [6:0]           half_q;
  logic signed [LW-1:0] len;
  logic signed [TW-1:0] timer, step_s, timer_dec;
  logic signed [LW-1:0] len_dec;
  logic                 wr_base, wr_len, wr_ctl, expire, unused_bits;

  assign wr_base   = cpu_wr && cpu_addr == A_BASE;
  assign wr_len    = cpu_wr && cpu_addr == A_LEN;
  assign wr_ctl    = cpu_wr && cpu_addr == A_CTL;
  assign step_s    = {{(TW-STEP_W){1'b0}}, cyc_step};
  assign timer_dec = timer - step_s;
  assign len_dec   = len - LW'(1);
  assign expire    = en && cyc_tick && (timer_dec <= 0);
  assign status_out  = {done, base_status[6:0]};
  assign irq         = done;
  assign unused_bits = ^{mem_rdata[0], base_status[7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      done     <= 1'b0;
      timer    <= PER_S;
      len      <= '0;
      mem_addr <= '0;
      mem_req  <= 1'b0;
      half_q   <= '0;
      dac_pend <= 1'b0;
      dac_val  <= '0;
    end else begin
      dac_pend <= 1'b0;
      if (dac_pend) dac_val <= half_q;
      if (mem_req && mem_ack) begin
        mem_req  <= 1'b0;
        half_q   <= mem_rdata[7:1];
        dac_pend <= 1'b1;
        mem_addr <= mem_addr + AW'(1);
      end
      if (en && cyc_tick) begin
        if (expire) begin
          timer <= timer_dec + PER_S;
          len   <= len_dec;
          if (len_dec < 0) begin
            done <= 1'b1;
            en   <= 1'b0;
          end else if (!mem_req || mem_ack) begin
            mem_req <= 1'b1;
          end
        end else begin
          timer <= timer_dec;
        end
      end
      if (wr_base) mem_addr <= AW'({cpu_wdata, 6'b0});
      if (wr_len)  len      <= LW'({cpu_wdata, 4'b0001});
      if (wr_ctl) begin
        en   <= cpu_wdata[4];
        done <= 1'b0;
        if (cpu_wdata[4]) timer <= PER_S;
      end
    end
  end
endmodule

// File: rtl/pcm_sample_player_chk.sv
module pcm_sample_player_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic [15:0]   cpu_addr,
  input logic [7:0]    status_out,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [7:0]    mem_rdata,
  input logic [6:0]    dac_val,
  input logic          irq,
  input logic          en
);
  logic base_wr;
  assign base_wr = cpu_wr && cpu_addr == 16'h4012;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !base_wr) |=> (mem_req && $stable(mem_addr)));

  assert_dac_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> ##1 (dac_val == $past(mem_rdata[7:1], 2)));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !base_wr) |=> (mem_addr == $past(mem_addr) + AW'(1)));

  assert_status_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[7] == irq);

  assert_ctl_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h4015) |=> !irq);

  assert_stop_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !en);
endmodule

bind pcm_sample_player pcm_sample_player_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .status_out(status_out), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dac_val(dac_val),
  .irq(irq), .en(en)
);

// File: tb/pcm_sample_player_test.sv
`timescale 1ns/1ps
module pcm_sample_player_test;
  logic        clk = 0, rst_n = 0;
  logic        cpu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, base_status = 0, status_out, mem_rdata = 0;
  logic        cyc_tick = 0, mem_req, mem_ack = 0, irq;
  logic [7:0]  cyc_step = 0;
  logic [14:0] mem_addr;
  logic [6:0]  dac_val;
  int checks = 0, errors = 0, fetch_count = 0;
  logic [14:0] last_addr = 0;

  always #4 clk = ~clk;

  pcm_sample_player uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .base_status(base_status), .status_out(status_out),
    .cyc_tick(cyc_tick), .cyc_step(cyc_step), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dac_val(dac_val), .irq(irq)
  );

  function automatic logic [7:0] mem_fn(input logic [14:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else if (mem_req && !mem_ack) begin
      mem_ack     <= 1;
      mem_rdata   <= mem_fn(mem_addr);
      last_addr   <= mem_addr;
      fetch_count <= fetch_count + 1;
    end else mem_ack <= 0;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic tick(input int step);
    @(negedge clk); cyc_tick = 1; cyc_step = 8'(step);
    @(negedge clk); cyc_tick = 0;
  endtask

  task automatic ticks(input int n, input int step);
    for (int i = 0; i < n; i++) tick(step);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    base_status = 8'hC3;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 dac", dac_val, 0);
    check("R9 status", status_out, 8'h43);
    ticks(60, 6); settle();
    check("R10 no fetch before start", fetch_count, 0);
  endtask

  task automatic t_single();
    int f0;
    base_status = 8'h00;
    cpu_write(16'h4012, 8'h11);
    cpu_write(16'h4013, 8'h00);
    cpu_write(16'h4015, 8'h10);
    f0 = fetch_count;
    ticks(40, 6); settle();
    check("R5 no fetch before 246 cycles", fetch_count - f0, 0);
    tick(6); settle();
    check("R5 fetch at 246 cycles", fetch_count - f0, 1);
    check("R2 first address", last_addr, 15'h440);
    check("R6 dac value", dac_val, int'(mem_fn(15'h440) >> 1));
    check("R8 no irq yet", irq, 0);
    ticks(40, 6); settle();
    check("R8 irq not early", irq, 0);
    tick(6); settle();
    check("R3 single fetch for count 0", fetch_count - f0, 1);
    check("R8 irq set", irq, 1);
    check("R9 status flag", status_out, 8'h80);
    ticks(100, 6); settle();
    check("R8 stopped after done", fetch_count - f0, 1);
  endtask

  task automatic t_clear();
    int f0;
    f0 = fetch_count;
    cpu_write(16'h4015, 8'hEF);
    @(negedge clk);
    check("R4 irq cleared", irq, 0);
    check("R9 status cleared", status_out[7], 0);
    ticks(60, 6); settle();
    check("R10 ticks ignored when stopped", fetch_count - f0, 0);
  endtask

  task automatic t_carry();
    int f0;
    cpu_write(16'h4012, 8'h02);
    cpu_write(16'h4013, 8'h01);
    cpu_write(16'h4015, 8'h10);
    f0 = fetch_count;
    ticks(49, 5); settle();
    check("R5 none after 245 cycles", fetch_count - f0, 0);
    tick(5); settle();
    check("R5 first fetch at 250", fetch_count - f0, 1);
    check("R2 address 0x80", last_addr, 15'h080);
    ticks(48, 5); settle();
    check("R5 carry: none after 240 more", fetch_count - f0, 1);
    tick(5); settle();
    check("R5 carry: fetch after 245 more", fetch_count - f0, 2);
    check("R7 increment", last_addr, 15'h081);
    cpu_write(16'h4015, 8'h00);
    ticks(100, 5); settle();
    check("R4 stop mid-play", fetch_count - f0, 2);
    check("R4 no irq on stop", irq, 0);
  endtask

  task automatic t_wrap();
    logic [14:0] exp_a;
    int f0, errs0;
    cpu_write(16'h4012, 8'hFF);
    exp_a = 15'h3FC0;
    for (int run = 0; run < 5; run++) begin
      cpu_write(16'h4013, 8'hFF);
      cpu_write(16'h4015, 8'h10);
      f0 = fetch_count;
      errs0 = errors;
      for (int k = 0; k < 4081; k++) begin
        tick(246);
        @(negedge clk);
        if (last_addr != exp_a) begin
          checks++; errors++;
          $display("FAIL R7 address actual=%0h expected=%0h", last_addr, exp_a);
        end
        if (exp_a == 15'h0000) check("R7 wrap to zero", last_addr, 0);
        exp_a = exp_a + 15'd1;
        if (errors - errs0 > 5) break;
      end
      tick(246); settle();
      check("R3 count 0xFF gives 4081 fetches", fetch_count - f0, 4081);
      check("R8 irq after run", irq, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_clear();
    t_carry();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule